// File: doc/BRIEF.md
# USB Transceiver Power-State Controller

This block is the power manager on the transceiver side of a low-pin-count USB link interface. It follows four operating states: normal operation, a link-requested low-power state, a timed wake-up phase and a pin-requested sleep state. It drives the direction line, an enable for the gated interface clock, an enable for the bidirectional data-bus pads, and two power-down indications. One is for the internal core. The other is for the full-speed receiver. All of its timing is counted on a free-running reference clock, which is never gated.

The link puts the transceiver into low power by clearing the suspend bit of the function control register through a simple write port. A write port cycle is a request plus an address and data byte, and the block answers with an accept signal in the same cycle. The link wakes the transceiver by raising its stop line, and that line may be asynchronous. Separately, the board can put the transceiver to sleep by holding the reset pin low while the chip-select pin is also low. Raising the reset pin brings it out of sleep. A combinational read port returns four fixed identification bytes and the function control register.

Top module: `usb_pwr_ctl`

## Requirements
- R1: In normal state, an accepted write to address 04h whose bit 6 (the suspend bit, active low) is 0 stores the byte in the function control register and enters low power on the next clock edge.
- R2: Once low power is entered, `clk_en_o` stays low for at least GATE_MIN (default 5) reference cycles, even if the stop line is already high.
- R3: In low power, `dir_o`=1, `core_pd_o`=1, `fsrx_pd_o`=0, `bus_oe_o`=1 and `clk_en_o`=0.
- R4: The stop line passes through a two-flop synchronizer. When its synchronized value is high and the gate time is over, the block enters wake-up, with the core powered, `clk_en_o`=1 and `dir_o`=1, for WAKE_CYC+1 cycles.
- R5: After wake-up, the block returns to normal (`dir_o`=0, `clk_en_o`=1, both power-downs 0) and bit 6 of register 04h reads 1.
- R6: Sleep is entered only from normal state, once the synchronized reset pin and chip-select pin have both been low for T_STATE+1 consecutive cycles.
- R7: In sleep, `bus_oe_o`=0, `dir_o`=0, `clk_en_o`=0, `core_pd_o`=1, `fsrx_pd_o`=1, and no write is accepted.
- R8: A synchronized high on the reset pin in sleep returns the block to normal, and register 04h returns to its default 41h.
- R9: A reset-pin low shorter than the required time, or one made while chip select is high, does not cause sleep, and the hold count restarts from zero.
- R10: Reads of addresses 00h, 01h, 02h and 03h return B4h, 04h, 03h and 68h. Writes to those addresses are ignored. Other unmapped addresses read 00h.
- R11: `wr_ack_o` is high only when a request is made in normal state. When sleep entry and a suspend write fall in the same cycle, sleep wins and the write is not accepted.
- R12: After power-on reset, the block is in normal state and register 04h reads 41h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_req_i | input | 1 | Register write request |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 8 | Register write data |
| wr_ack_o | output | 1 | Write accepted this cycle |
| rd_addr_i | input | 6 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| stp_i | input | 1 | Stop line from the link, asynchronous |
| pin_reset_n_i | input | 1 | Reset pin, active low, asynchronous |
| pin_cs_n_i | input | 1 | Chip-select pin, active low, asynchronous |
| dir_o | output | 1 | Data-bus direction, 1 = transceiver drives |
| clk_en_o | output | 1 | Enable for the gated interface clock |
| bus_oe_o | output | 1 | Data-bus pad enable, 0 = tri-stated |
| core_pd_o | output | 1 | Internal core power-down |
| fsrx_pd_o | output | 1 | Full-speed receiver power-down |

## Verification
Two events can fall in the same cycle. In one, the sleep hold time completes. In the other, the link issues a write that clears the suspend bit. The bench provokes this by holding both pins low and watching its own model's hold count. It issues the suspend write in exactly the cycle where that count reaches its limit. The bench then checks that the write is refused, and on the next cycle it checks that the sleep outputs appear rather than the low-power ones.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;

   typedef enum logic [1:0] {
      PS_NORMAL = 2'd0,
      PS_LOWPWR = 2'd1,
      PS_WAKING = 2'd2,
      PS_SLEEP  = 2'd3
   } pwr_state_e;

   localparam logic [5:0] FCTL_ADDR  = 6'h04;
   localparam int         SUSP_BIT   = 6;
   localparam logic [7:0] FCTL_RESET = 8'h41;

   function automatic logic [7:0] id_byte(input logic [1:0] idx);
      case (idx)
         2'd0:    id_byte = 8'hB4;
         2'd1:    id_byte = 8'h04;
         2'd2:    id_byte = 8'h03;
         default: id_byte = 8'h68;
      endcase
   endfunction

endpackage

// File: rtl/usb_pwr_sync.sv
module usb_pwr_sync #(
   parameter int         WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("usb_pwr_sync: WIDTH must be at least 1");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic meta_q, stab_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               meta_q <= RST_VAL[b];
               stab_q <= RST_VAL[b];
            end else begin
               meta_q <= async_i[b];
               stab_q <= meta_q;
            end
         end
         assign sync_o[b] = stab_q;
      end
   endgenerate
endmodule

// File: rtl/usb_pwr_cnt.sv
module usb_pwr_cnt #(
   parameter int LIMIT = 5,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o,
   output logic          done_o
);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("usb_pwr_cnt: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)            cnt_q <= '0;
      else if (clr_i)        cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign done_o = (cnt_q == LIM);

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!por_n)
      (!clr_i && cnt_q == LIM) |=> (cnt_q == LIM)); // R2
endmodule

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs
   import usb_pwr_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          wr_en_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          wake_done_i,
   input  logic          sleep_exit_i,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o,
   output logic          suspend_m_o
);
   localparam logic [AW-1:0] FC_A   = AW'(FCTL_ADDR);
   localparam logic [AW-1:0] ID_TOP = AW'(4);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("usb_pwr_regs: DW must be 8");
      end
      if (AW < 3) begin : g_bad_aw
         $error("usb_pwr_regs: AW must be at least 3");
      end
   endgenerate

   logic [DW-1:0] fctl_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         fctl_q <= FCTL_RESET;
      end else if (sleep_exit_i) begin
         fctl_q <= FCTL_RESET;
      end else if (wake_done_i) begin
         fctl_q[SUSP_BIT] <= 1'b1;
      end else if (wr_en_i && wr_addr_i == FC_A) begin
         fctl_q <= wr_data_i;
      end
   end

   always_comb begin
      if (rd_addr_i < ID_TOP)      rd_data_o = id_byte(rd_addr_i[1:0]);
      else if (rd_addr_i == FC_A)  rd_data_o = fctl_q;
      else                         rd_data_o = '0;
   end

   assign suspend_m_o = fctl_q[SUSP_BIT];

   AST_EXIT_DEFAULT: assert property (@(posedge clk) disable iff (!por_n)
      sleep_exit_i |=> (fctl_q == FCTL_RESET)); // R8
endmodule

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl
   import usb_pwr_pkg::*;
#(
   parameter int T_STATE  = 16,
   parameter int GATE_MIN = 5,
   parameter int WAKE_CYC = 8,
   parameter int AW       = 6,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          wr_req_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic [DW-1:0] wr_data_i,
   output logic          wr_ack_o,
   input  logic [AW-1:0] rd_addr_i,
   output logic [DW-1:0] rd_data_o,
   input  logic          stp_i,
   input  logic          pin_reset_n_i,
   input  logic          pin_cs_n_i,
   output logic          dir_o,
   output logic          clk_en_o,
   output logic          bus_oe_o,
   output logic          core_pd_o,
   output logic          fsrx_pd_o
);
   localparam int HCW = $clog2(T_STATE + 1);
   localparam int GCW = $clog2(GATE_MIN + 1);
   localparam int WCW = $clog2(WAKE_CYC + 1);
   localparam logic [AW-1:0] FC_A = AW'(FCTL_ADDR);

   generate
      if (GATE_MIN < 5) begin : g_bad_gate
         $error("usb_pwr_ctl: GATE_MIN below the five-cycle minimum");
      end
   endgenerate

   // stp, reset pin, chip select
   logic [2:0] pins_s;
   logic       stp_s, rst_s, cs_s;

   usb_pwr_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
      .clk     (clk),
      .por_n   (por_n),
      .async_i ({pin_reset_n_i, pin_cs_n_i, stp_i}),
      .sync_o  (pins_s)
   );
   assign {rst_s, cs_s, stp_s} = pins_s;

   pwr_state_e st_q, st_d;
   logic       qual, sleep_go, gate_done, wake_done, hold_done;
   logic       wr_en, wake_exit, sleep_exit, suspend_m;
   logic [HCW-1:0] hold_cnt;
   logic [GCW-1:0] gate_cnt;
   logic [WCW-1:0] wake_cnt;

   assign qual = !rst_s && !cs_s;

   usb_pwr_cnt #(.LIMIT(T_STATE)) u_hold (
      .clk(clk), .por_n(por_n), .clr_i(!(st_q == PS_NORMAL && qual)),
      .cnt_o(hold_cnt), .done_o(hold_done));

   usb_pwr_cnt #(.LIMIT(GATE_MIN)) u_gate (
      .clk(clk), .por_n(por_n), .clr_i(st_q != PS_LOWPWR),
      .cnt_o(gate_cnt), .done_o(gate_done));

   usb_pwr_cnt #(.LIMIT(WAKE_CYC)) u_wake (
      .clk(clk), .por_n(por_n), .clr_i(st_q != PS_WAKING),
      .cnt_o(wake_cnt), .done_o(wake_done));

   assign sleep_go   = (st_q == PS_NORMAL) && qual && hold_done;
   assign wr_ack_o   = wr_req_i && (st_q == PS_NORMAL) && !sleep_go;
   assign wr_en      = wr_ack_o;
   assign wake_exit  = (st_q == PS_WAKING) && wake_done;
   assign sleep_exit = (st_q == PS_SLEEP) && rst_s;

   always_comb begin
      st_d = st_q;
      case (st_q)
         PS_NORMAL: begin
            if (sleep_go)
               st_d = PS_SLEEP;
            else if (wr_en && wr_addr_i == FC_A && !wr_data_i[SUSP_BIT])
               st_d = PS_LOWPWR;
         end
         PS_LOWPWR: if (stp_s && gate_done) st_d = PS_WAKING;
         PS_WAKING: if (wake_done)          st_d = PS_NORMAL;
         default:   if (rst_s)              st_d = PS_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st_q <= PS_NORMAL;
      else        st_q <= st_d;
   end

   usb_pwr_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk(clk), .por_n(por_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .wake_done_i(wake_exit), .sleep_exit_i(sleep_exit),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .suspend_m_o(suspend_m));

   always_comb begin
      dir_o     = (st_q == PS_LOWPWR) || (st_q == PS_WAKING);
      clk_en_o  = (st_q == PS_NORMAL) || (st_q == PS_WAKING);
      bus_oe_o  = (st_q != PS_SLEEP);
      core_pd_o = (st_q == PS_LOWPWR) || (st_q == PS_SLEEP);
      fsrx_pd_o = (st_q == PS_SLEEP);
   end

   AST_LP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ack_o && wr_addr_i == FC_A && !wr_data_i[SUSP_BIT]) |=> (st_q == PS_LOWPWR)); // R1
   AST_GATE_MIN: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_LOWPWR && !gate_done) |=> !clk_en_o); // R2
   AST_STP_NEEDED: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_LOWPWR && !stp_s) |=> dir_o && core_pd_o); // R4
   AST_WAKE_SETS_SUSP: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_WAKING) |=> (st_q == PS_WAKING || suspend_m)); // R5
   AST_SLEEP_FROM_NORMAL: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_LOWPWR || st_q == PS_WAKING) |=> bus_oe_o); // R6
   AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == PS_NORMAL && (rst_s || cs_s)) |=> bus_oe_o); // R9
endmodule

// File: tb/usb_pwr_ctl_tb.sv
module usb_pwr_ctl_tb;
   localparam int T  = 16;
   localparam int G  = 5;
   localparam int W  = 8;

   logic clk = 0, por_n = 0;
   logic wr_req = 0; logic [5:0] wr_addr = 0; logic [7:0] wr_data = 0;
   logic [5:0] rd_addr = 0; logic [7:0] rd_data;
   logic wr_ack, stp = 0, rst_pin = 1, cs_pin = 1;
   logic dir, clk_en, bus_oe, core_pd, fsrx_pd;

   always #10 clk = ~clk;

   usb_pwr_ctl #(.T_STATE(T), .GATE_MIN(G), .WAKE_CYC(W)) u_dut (
      .clk(clk), .por_n(por_n), .wr_req_i(wr_req), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .wr_ack_o(wr_ack), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .stp_i(stp), .pin_reset_n_i(rst_pin),
      .pin_cs_n_i(cs_pin), .dir_o(dir), .clk_en_o(clk_en), .bus_oe_o(bus_oe),
      .core_pd_o(core_pd), .fsrx_pd_o(fsrx_pd));

   int checks = 0, errors = 0;
   bit finished = 0;

   // Reference model: 0 normal, 1 low power, 2 waking, 3 sleep
   int m_st, m_hold, m_gate, m_wake, m_fctl;
   int m_rs1, m_rs2, m_cs1, m_cs2, m_sp1, m_sp2;

   function automatic int id_of(int a);
      int ids[4] = '{8'hB4, 8'h04, 8'h03, 8'h68};
      return ids[a];
   endfunction

   function automatic bit m_sleep_go();
      return m_st == 0 && m_rs2 == 0 && m_cs2 == 0 && m_hold == T;
   endfunction

   always @(posedge clk) begin
      if (!por_n) begin
         m_st = 0; m_hold = 0; m_gate = 0; m_wake = 0; m_fctl = 8'h41;
         m_rs1 = 1; m_rs2 = 1; m_cs1 = 1; m_cs2 = 1; m_sp1 = 0; m_sp2 = 0;
      end else begin
         bit q, go, ack; int nst, nh, ng, nw;
         q   = (m_rs2 == 0 && m_cs2 == 0);
         go  = m_sleep_go();
         ack = wr_req && m_st == 0 && !go;
         nh  = (m_st == 0 && q) ? ((m_hold < T) ? m_hold + 1 : T) : 0;
         ng  = (m_st == 1) ? ((m_gate < G) ? m_gate + 1 : G) : 0;
         nw  = (m_st == 2) ? ((m_wake < W) ? m_wake + 1 : W) : 0;
         nst = m_st;
         case (m_st)
            0: if (go) nst = 3;
               else if (ack && wr_addr == 4 && !wr_data[6]) nst = 1;
            1: if (m_sp2 == 1 && m_gate == G) nst = 2;
            2: if (m_wake == W) nst = 0;
            default: if (m_rs2 == 1) nst = 0;
         endcase
         if (m_st == 3 && m_rs2 == 1)      m_fctl = 8'h41;
         else if (m_st == 2 && m_wake == W) m_fctl = m_fctl | 8'h40;
         else if (ack && wr_addr == 4)      m_fctl = wr_data;
         m_st = nst; m_hold = nh; m_gate = ng; m_wake = nw;
         m_rs2 = m_rs1; m_rs1 = rst_pin;
         m_cs2 = m_cs1; m_cs1 = cs_pin;
         m_sp2 = m_sp1; m_sp1 = stp;
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison, sampled 2 ns after the falling edge
   always @(negedge clk) begin
      #2;
      if (por_n && !finished) begin
         string rq; int e_dir, e_ce, e_oe, e_cp, e_fp, e_rd; bit e_ack;
         case (m_st)
            0: begin rq = "R5"; e_dir = 0; e_ce = 1; e_oe = 1; e_cp = 0; e_fp = 0; end
            1: begin rq = "R3"; e_dir = 1; e_ce = 0; e_oe = 1; e_cp = 1; e_fp = 0; end
            2: begin rq = "R4"; e_dir = 1; e_ce = 1; e_oe = 1; e_cp = 0; e_fp = 0; end
            default: begin rq = "R7"; e_dir = 0; e_ce = 0; e_oe = 0; e_cp = 1; e_fp = 1; end
         endcase
         chk({dir, clk_en, bus_oe, core_pd, fsrx_pd} ==
             {e_dir[0], e_ce[0], e_oe[0], e_cp[0], e_fp[0]}, rq,
             {dir, clk_en, bus_oe, core_pd, fsrx_pd},
             {e_dir[0], e_ce[0], e_oe[0], e_cp[0], e_fp[0]});
         e_ack = wr_req && m_st == 0 && !m_sleep_go();
         chk(wr_ack == e_ack, "R11 ack", wr_ack, e_ack);
         e_rd = (rd_addr < 4) ? id_of(rd_addr) : (rd_addr == 4) ? m_fctl : 0;
         chk(rd_data == e_rd[7:0], "R10 read", rd_data, e_rd);
      end
   end

   always @(negedge clk) if (por_n && !finished) rd_addr <= (rd_addr == 6) ? 0 : rd_addr + 1;

   task automatic cyc(int n); repeat (n) @(negedge clk); endtask

   task automatic wr(int a, int d);
      @(negedge clk); wr_req = 1; wr_addr = a[5:0]; wr_data = d[7:0];
      @(negedge clk); wr_req = 0;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
   end

   initial begin
      int lowrun;
      cyc(3); por_n = 1;
      @(negedge clk); #3;
      // R12 reset state
      chk(bus_oe && clk_en && !dir && !core_pd, "R12 state", {dir, clk_en, bus_oe}, 3'b011);
      // R10 writes to ID addresses ignored
      wr(0, 8'h00); wr(3, 8'hFF);
      cyc(12);
      // write 04h keeping suspend bit high: stays normal
      wr(4, 8'h45); cyc(3); #3;
      chk(!dir && m_fctl == 8'h45, "R1 no-suspend write", dir, 0);
      // R1/R2: suspend with STP already high
      stp = 1;
      wr(4, 8'h05); #3;
      chk(dir && !clk_en, "R1 enter low power", {dir, clk_en}, 2'b10);
      lowrun = 1;
      while (!clk_en) begin @(negedge clk); #3; if (!clk_en) lowrun++; end
      chk(lowrun >= G, "R2 clock gated", lowrun, G);
      cyc(W + 2); #3;
      chk(!dir && rd_addr >= 0 && m_fctl[6], "R5 suspend bit restored", dir, 0);
      stp = 0; cyc(4);
      // R4: STP late, held in low power meanwhile
      wr(4, 8'h01); cyc(12); #3;
      chk(dir && core_pd, "R4 waits for stp", {dir, core_pd}, 2'b11);
      stp = 1; cyc(W + 6); stp = 0; cyc(3);
      // R9: short low pulse, then low while CS high
      cs_pin = 0; rst_pin = 0; cyc(T - 4); rst_pin = 1; cyc(4); #3;
      chk(bus_oe, "R9 short pulse", bus_oe, 1);
      rst_pin = 0; cyc(T - 2); rst_pin = 1; cyc(3);
      cs_pin = 1; rst_pin = 0; cyc(T + 10); #3;
      chk(bus_oe, "R9 cs high", bus_oe, 1);
      rst_pin = 1; cyc(3);
      // R6/R7/R8: sleep entry and exit
      wr(4, 8'h4A);
      cs_pin = 0; rst_pin = 0; cyc(T + 4); #3;
      chk(!bus_oe && fsrx_pd, "R6 sleep entered", bus_oe, 0);
      @(negedge clk); wr_req = 1; wr_addr = 4; wr_data = 8'h00; #3;
      chk(!wr_ack, "R7 no write in sleep", wr_ack, 0);
      @(negedge clk); wr_req = 0;
      rst_pin = 1; cs_pin = 1; cyc(4); #3;
      chk(bus_oe && m_fctl == 8'h41, "R8 sleep exit default", bus_oe, 1);
      // R6: pins low during low power do not cause sleep
      wr(4, 8'h01);
      cs_pin = 0; rst_pin = 0; cyc(T + 6); #3;
      chk(bus_oe && dir, "R6 not from low power", {bus_oe, dir}, 2'b11);
      stp = 1; cyc(W + 4); stp = 0;
      cyc(T + 4); #3;
      chk(!bus_oe, "R6 sleep after return", bus_oe, 0);
      rst_pin = 1; cs_pin = 1; cyc(4);
      // R11: suspend write in the very cycle sleep completes
      cs_pin = 0; rst_pin = 0;
      while (!(m_st == 0 && m_hold == T && m_rs2 == 0 && m_cs2 == 0)) @(negedge clk);
      wr_req = 1; wr_addr = 4; wr_data = 8'h05; #3;
      chk(!wr_ack, "R11 collision refused", wr_ack, 0);
      @(negedge clk); wr_req = 0; #3;
      chk(!bus_oe && !dir, "R11 sleep wins", {bus_oe, dir}, 2'b00);
      rst_pin = 1; cs_pin = 1; cyc(5);
      finish_run();
   end
endmodule